// File: doc/BRIEF.md
# Command and Interrupt Status Register Block

This block is the host-facing register window of a network controller. Internal engines report events to it as single-cycle pulses. The block latches each event as a pending cause bit in a 16-bit status word, and the host clears a cause by writing a one to it. The same status word shows the live state of the command engine and the receive engine. A single interrupt line is raised while any cause is pending, unless the host has masked it.

The host issues work by writing a command byte. The upper nibble goes to the command engine and the lower nibble goes to the receive engine. For each nibble, a small state machine (`hcs_unit_port`) offers the code to its engine. The nibble reads back nonzero until that engine returns an accept strobe, which gives the host a polling handshake.

Each unit-port machine has two states. In `US_EMPTY` it offers nothing. The transition `EMPTY->OFFERED` happens when a nonzero nibble is written. In `US_OFFERED` it holds the code, and for the start and load-base codes it also holds a snapshot of the 32-bit pointer register. The transition `OFFERED->EMPTY` happens on the engine's accept strobe. The host reaches everything through one 32-bit word port with byte enables. Word 0 holds the status, acknowledge, command and interrupt-control bytes at byte lanes 0 to 3. Word 1 holds the pointer.

Top module: `host_cmd_status_regs`

## Requirements
- R1: After reset, all pending causes, both command nibbles, the mask bit, the pointer register, `irq_o` and both command-valid outputs are zero.
- R2: Status bits 7:6 show `cu_state_i` live (idle 00, suspended 01, active 10). Bits 5:0 show `ru_state_i` live (idle 0x00, suspended 0x04, no resources 0x08, ready 0x10). Bits 9:8 read 0. Writes to byte lane 0 have no effect.
- R3: A pulse on `evt_i[k]` sets status bit 11+k, where bit 15 is command done, bit 14 is frame received, bit 13 is command engine left active, bit 12 is receive engine not ready and bit 11 is management access done. The bit is readable one cycle after the pulse.
- R4: A write to byte lane 1 clears each cause whose bit is written as 1 (data bit 15..10 for status bit 15..10). Causes written as 0 keep their value.
- R5: If an event and an acknowledge of the same cause fall in the same cycle, the cause stays pending.
- R6: `irq_o` is high exactly when some cause is pending and the mask bit (word-0 bit 24) is 0. The mask bit reads back at bit 24.
- R7: Writing 1 to word-0 bit 25 sets the software cause at status bit 10. Bit 25 always reads 0.
- R8: Writing byte lane 2 with a nonzero nibble raises that engine's valid output in the next cycle and presents the code: bits 23:20 go to the command engine and bits 19:16 go to the receive engine. The byte reads back the pending codes.
- R9: An accept strobe clears only its own engine's nibble and valid output. The command byte reads 0x00 only after every nonzero nibble has been accepted. An accept with nothing pending has no effect.
- R10: A nonzero nibble written while that engine already has a pending code is ignored. A zero nibble leaves its engine untouched.
- R11: Word 1 is a 32-bit pointer register with per-byte write enables. Codes 0x1 (start) and 0x6 (load base) carry a snapshot of the pointer. All other codes present a pointer of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_sel | input | 1 | Word select: 0 control/status word, 1 pointer word |
| acc_we | input | 1 | Write strobe |
| acc_be | input | 4 | Byte enables for the write |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data of the selected word |
| evt_i | input | 5 | Engine event pulses (bit k sets status bit 11+k) |
| cu_state_i | input | 2 | Command engine state |
| ru_state_i | input | 6 | Receive engine state |
| cu_cmd_valid_o | output | 1 | Command engine has a pending code |
| cu_cmd_code_o | output | 4 | Pending command engine code |
| cu_cmd_ptr_o | output | 32 | Pointer delivered with the command engine code |
| cu_accept_i | input | 1 | Command engine accepts its code |
| ru_cmd_valid_o | output | 1 | Receive engine has a pending code |
| ru_cmd_code_o | output | 4 | Pending receive engine code |
| ru_cmd_ptr_o | output | 32 | Pointer delivered with the receive engine code |
| ru_accept_i | input | 1 | Receive engine accepts its code |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that event inputs and accept strobes are held low during reset. They also assume that an accept strobe is a single-cycle pulse driven on a clock edge, so that a held code can only change through the handshake. The stimulus drives every input on the falling edge. Events and accepts are raised for one cycle only. The collision case is built deliberately, by lining up an event pulse and an acknowledge write on the same edge.

// File: rtl/hcs_pkg.sv
package hcs_pkg;

    localparam int CAUSE_N  = 6;
    localparam int EVT_N    = CAUSE_N - 1;
    localparam int NIB_W    = 4;
    localparam int UNIT_N   = 2;
    localparam int CAUSE_LO = 10;

    typedef enum logic [0:0] {
        US_EMPTY   = 1'b0,
        US_OFFERED = 1'b1
    } unit_state_e;

    localparam logic [NIB_W-1:0] CODE_START = 4'h1;
    localparam logic [NIB_W-1:0] CODE_LOAD  = 4'h6;

    function automatic logic code_takes_ptr(input logic [NIB_W-1:0] code);
        return (code == CODE_START) || (code == CODE_LOAD);
    endfunction

endpackage

// File: rtl/hcs_cause_bank.sv
module hcs_cause_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);

    logic [N-1:0] pend_q;

    generate
        for (genvar k = 0; k < N; k++) begin : g_bit
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend_q[k] <= 1'b0;
                end else if (set_i[k]) begin
                    pend_q[k] <= 1'b1;
                end else if (clr_i[k]) begin
                    pend_q[k] <= 1'b0;
                end
            end

            // R3 / R5: an event always leaves its cause pending
            assert_event_latched_R5: assert property (@(posedge clk) disable iff (!rst_n)
                set_i[k] |=> pend_o[k]);

            // R4: acknowledge without competing event clears
            assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[k] && !set_i[k]) |=> !pend_o[k]);
        end
    endgenerate

    assign pend_o = pend_q;

endmodule

// File: rtl/hcs_unit_port.sv
module hcs_unit_port
    import hcs_pkg::*;
#(
    parameter int PTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [NIB_W-1:0] nib_i,
    input  logic [PTR_W-1:0] ptr_i,
    input  logic             accept_i,
    output logic             valid_o,
    output logic [NIB_W-1:0] code_o,
    output logic [PTR_W-1:0] ptr_o
);

    unit_state_e      state_q, state_d;
    logic [NIB_W-1:0] code_q;
    logic [PTR_W-1:0] ptr_q;
    logic             take;

    assign take = (state_q == US_EMPTY) && wr_i && (nib_i != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= US_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            US_EMPTY:   if (take)     state_d = US_OFFERED;
            US_OFFERED: if (accept_i) state_d = US_EMPTY;
            default:                  state_d = US_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            ptr_q  <= '0;
        end else if (take) begin
            code_q <= nib_i;
            ptr_q  <= code_takes_ptr(nib_i) ? ptr_i : '0;
        end else if (state_q == US_OFFERED && accept_i) begin
            code_q <= '0;
            ptr_q  <= '0;
        end
    end

    always_comb begin
        valid_o = 1'b0;
        code_o  = '0;
        ptr_o   = '0;
        unique case (state_q)
            US_EMPTY: ;
            US_OFFERED: begin
                valid_o = 1'b1;
                code_o  = code_q;
                ptr_o   = ptr_q;
            end
            default: ;
        endcase
    end

    assert_accept_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && accept_i) |=> !valid_o);

    assert_code_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !accept_i) |=> (valid_o && $stable(code_o) && $stable(ptr_o)));

endmodule

// File: rtl/host_cmd_status_regs.sv
module host_cmd_status_regs
    import hcs_pkg::*;
#(
    parameter int PTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_sel,
    input  logic             acc_we,
    input  logic [3:0]       acc_be,
    input  logic [31:0]      acc_wdata,
    output logic [31:0]      acc_rdata,
    input  logic [EVT_N-1:0] evt_i,
    input  logic [1:0]       cu_state_i,
    input  logic [5:0]       ru_state_i,
    output logic             cu_cmd_valid_o,
    output logic [NIB_W-1:0] cu_cmd_code_o,
    output logic [PTR_W-1:0] cu_cmd_ptr_o,
    input  logic             cu_accept_i,
    output logic             ru_cmd_valid_o,
    output logic [NIB_W-1:0] ru_cmd_code_o,
    output logic [PTR_W-1:0] ru_cmd_ptr_o,
    input  logic             ru_accept_i,
    output logic             irq_o
);

    localparam int PTR_BYTES = PTR_W / 8;

    logic                 wr_ctl, wr_ptr;
    logic [CAUSE_N-1:0]   cause_set, cause_clr, pend;
    logic                 swi_set;
    logic                 mask_q;
    logic [PTR_W-1:0]     ptr_q;
    logic [UNIT_N-1:0]    u_accept, u_valid;
    logic [NIB_W-1:0]     u_code [UNIT_N];
    logic [PTR_W-1:0]     u_ptr  [UNIT_N];
    logic                 unused_bits;

    assign wr_ctl  = acc_we && !acc_sel;
    assign wr_ptr  = acc_we &&  acc_sel;
    assign swi_set = wr_ctl && acc_be[3] && acc_wdata[25];

    assign cause_set = {evt_i, swi_set};
    assign cause_clr = (wr_ctl && acc_be[1]) ? acc_wdata[CAUSE_LO +: CAUSE_N] : '0;

    hcs_cause_bank #(.N(CAUSE_N)) u_causes (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (cause_set),
        .clr_i  (cause_clr),
        .pend_o (pend)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 1'b0;
        end else if (wr_ctl && acc_be[3]) begin
            mask_q <= acc_wdata[24];
        end
    end

    generate
        for (genvar b = 0; b < PTR_BYTES; b++) begin : g_ptr
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ptr_q[8*b +: 8] <= '0;
                end else if (wr_ptr && acc_be[b % 4]) begin
                    ptr_q[8*b +: 8] <= acc_wdata[8*(b % 4) +: 8];
                end
            end
        end
    endgenerate

    assign u_accept = {cu_accept_i, ru_accept_i};

    generate
        for (genvar u = 0; u < UNIT_N; u++) begin : g_unit
            hcs_unit_port #(.PTR_W(PTR_W)) u_port (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_i     (wr_ctl && acc_be[2]),
                .nib_i    (acc_wdata[16 + NIB_W*u +: NIB_W]),
                .ptr_i    (ptr_q),
                .accept_i (u_accept[u]),
                .valid_o  (u_valid[u]),
                .code_o   (u_code[u]),
                .ptr_o    (u_ptr[u])
            );
        end
    endgenerate

    assign ru_cmd_valid_o = u_valid[0];
    assign ru_cmd_code_o  = u_code[0];
    assign ru_cmd_ptr_o   = u_ptr[0];
    assign cu_cmd_valid_o = u_valid[1];
    assign cu_cmd_code_o  = u_code[1];
    assign cu_cmd_ptr_o   = u_ptr[1];

    assign irq_o = (|pend) && !mask_q;

    always_comb begin
        if (acc_sel) begin
            acc_rdata = ptr_q[31:0];
        end else begin
            acc_rdata = {7'b0, mask_q, u_code[1], u_code[0],
                         pend, 2'b00, cu_state_i, ru_state_i};
        end
    end

    assign unused_bits = ^{acc_wdata[9:0], acc_wdata[31:26]};

    assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q |-> !irq_o);

endmodule

// File: tb/tb_host_cmd_status_regs.sv
module tb_host_cmd_status_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_sel = 1'b0, acc_we = 1'b0;
    logic [3:0]  acc_be = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic [4:0]  evt_i = '0;
    logic [1:0]  cu_state_i = '0;
    logic [5:0]  ru_state_i = '0;
    logic        cu_cmd_valid_o, ru_cmd_valid_o, irq_o;
    logic [3:0]  cu_cmd_code_o, ru_cmd_code_o;
    logic [31:0] cu_cmd_ptr_o, ru_cmd_ptr_o;
    logic        cu_accept_i = 1'b0, ru_accept_i = 1'b0;

    int total = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    host_cmd_status_regs dut (
        .clk(clk), .rst_n(rst_n), .acc_sel(acc_sel), .acc_we(acc_we),
        .acc_be(acc_be), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .evt_i(evt_i), .cu_state_i(cu_state_i), .ru_state_i(ru_state_i),
        .cu_cmd_valid_o(cu_cmd_valid_o), .cu_cmd_code_o(cu_cmd_code_o),
        .cu_cmd_ptr_o(cu_cmd_ptr_o), .cu_accept_i(cu_accept_i),
        .ru_cmd_valid_o(ru_cmd_valid_o), .ru_cmd_code_o(ru_cmd_code_o),
        .ru_cmd_ptr_o(ru_cmd_ptr_o), .ru_accept_i(ru_accept_i),
        .irq_o(irq_o)
    );

    // {events[4:0], ack bits 15..10, expected pending 15..10}
    localparam logic [16:0] VEC [8] = '{
        {5'b11111, 6'b111110, 6'b000000},
        {5'b11111, 6'b000000, 6'b111110},
        {5'b10000, 6'b010000, 6'b100000},
        {5'b00001, 6'b000010, 6'b000000},
        {5'b01010, 6'b100100, 6'b010000},
        {5'b00110, 6'b001000, 6'b000100},
        {5'b11001, 6'b111111, 6'b000000},
        {5'b10101, 6'b000110, 6'b101000}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        acc_sel = sel; acc_we = 1'b1; acc_be = be; acc_wdata = d;
        @(negedge clk);
        acc_we = 1'b0; acc_be = '0; acc_wdata = '0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] d);
        @(negedge clk);
        acc_sel = sel;
        #1 d = acc_rdata;
    endtask

    task automatic pulse_evt(input logic [4:0] m);
        @(negedge clk);
        evt_i = m;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic clear_all();
        wr(1'b0, 4'b0010, 32'h0000_FC00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(1'b0, r);
        chk("R1 word0 after reset", r, 32'h0);
        rd(1'b1, r);
        chk("R1 pointer after reset", r, 32'h0);
        chk("R1 irq/valids after reset", {29'b0, irq_o, cu_cmd_valid_o, ru_cmd_valid_o}, 32'h0);

        // R3 R4 table walk
        for (int i = 0; i < 8; i++) begin
            clear_all();
            pulse_evt(VEC[i][16:12]);
            wr(1'b0, 4'b0010, {16'h0, VEC[i][11:6], 10'h0});
            rd(1'b0, r);
            chk($sformatf("R4 vector %0d pending", i), {26'h0, r[15:10]}, {26'h0, VEC[i][5:0]});
            chk($sformatf("R6 vector %0d irq", i), {31'h0, irq_o}, {31'h0, VEC[i][5:0] != 6'h0});
        end

        // R3 single event position
        clear_all();
        pulse_evt(5'b00100);
        rd(1'b0, r);
        chk("R3 cu-left-active at bit 13", {16'h0, r[15:0]}, 32'h0000_2000);

        // R2 live state fields, lane 0 write ignored
        cu_state_i = 2'b10; ru_state_i = 6'h10;
        wr(1'b0, 4'b0001, 32'h0000_00FF);
        rd(1'b0, r);
        chk("R2 active/ready", {24'h0, r[7:0]}, 32'h90);
        cu_state_i = 2'b01; ru_state_i = 6'h08;
        rd(1'b0, r);
        chk("R2 suspended/no-resources", {22'h0, r[9:0]}, 32'h48);
        cu_state_i = 2'b00; ru_state_i = 6'h00;

        // R5 event and ack same cycle
        clear_all();
        @(negedge clk);
        evt_i = 5'b10000;
        acc_sel = 1'b0; acc_we = 1'b1; acc_be = 4'b0010; acc_wdata = 32'h0000_8000;
        @(negedge clk);
        evt_i = '0; acc_we = 1'b0; acc_be = '0; acc_wdata = '0;
        rd(1'b0, r);
        chk("R5 event beats ack", {31'h0, r[15]}, 32'h1);

        // R6 mask
        wr(1'b0, 4'b1000, 32'h0100_0000);
        rd(1'b0, r);
        chk("R6 mask readback", {31'h0, r[24]}, 32'h1);
        chk("R6 irq masked", {31'h0, irq_o}, 32'h0);
        wr(1'b0, 4'b1000, 32'h0000_0000);
        #1 chk("R6 irq unmasked", {31'h0, irq_o}, 32'h1);

        // R7 software cause
        clear_all();
        wr(1'b0, 4'b1000, 32'h0200_0000);
        rd(1'b0, r);
        chk("R7 software cause bit 10", {16'h0, r[15:0]}, 32'h0000_0400);
        chk("R7 bit 25 reads zero", {31'h0, r[25]}, 32'h0);
        clear_all();

        // R11 pointer with byte lanes
        wr(1'b1, 4'b1111, 32'h1234_5678);
        wr(1'b1, 4'b0001, 32'h0000_00AA);
        rd(1'b1, r);
        chk("R11 pointer byte lane", r, 32'h1234_56AA);

        // R8 command issue: CU resume 2, RU start 1
        wr(1'b0, 4'b0100, 32'h0021_0000);
        rd(1'b0, r);
        chk("R8 command byte readback", {24'h0, r[23:16]}, 32'h21);
        chk("R8 cu valid/code", {27'h0, cu_cmd_valid_o, cu_cmd_code_o}, 32'h12);
        chk("R8 ru valid/code", {27'h0, ru_cmd_valid_o, ru_cmd_code_o}, 32'h11);
        chk("R11 ru start carries pointer", ru_cmd_ptr_o, 32'h1234_56AA);
        chk("R11 cu resume pointer zero", cu_cmd_ptr_o, 32'h0);

        // R10 write while pending ignored
        wr(1'b0, 4'b0100, 32'h0046_0000);
        rd(1'b0, r);
        chk("R10 pending codes kept", {24'h0, r[23:16]}, 32'h21);

        // R9 accepts
        @(negedge clk); ru_accept_i = 1'b1;
        @(negedge clk); ru_accept_i = 1'b0;
        rd(1'b0, r);
        chk("R9 after ru accept", {24'h0, r[23:16]}, 32'h20);
        chk("R9 ru valid low, cu still high", {30'h0, cu_cmd_valid_o, ru_cmd_valid_o}, 32'h2);
        @(negedge clk); cu_accept_i = 1'b1;
        @(negedge clk); cu_accept_i = 1'b0;
        rd(1'b0, r);
        chk("R9 byte clear after both", {24'h0, r[23:16]}, 32'h0);
        @(negedge clk); cu_accept_i = 1'b1; ru_accept_i = 1'b1;
        @(negedge clk); cu_accept_i = 1'b0; ru_accept_i = 1'b0;
        rd(1'b0, r);
        chk("R9 stray accept no effect", {24'h0, r[23:16]}, 32'h0);

        // R10 zero nibble, R11 load base pointer
        wr(1'b0, 4'b0100, 32'h0060_0000);
        rd(1'b0, r);
        chk("R10 zero ru nibble", {24'h0, r[23:16]}, 32'h60);
        chk("R11 cu load base pointer", cu_cmd_ptr_o, 32'h1234_56AA);
        wr(1'b0, 4'b0100, 32'h0004_0000);
        rd(1'b0, r);
        chk("R10 ru taken, cu kept", {24'h0, r[23:16]}, 32'h64);
        chk("R11 ru abort pointer zero", ru_cmd_ptr_o, 32'h0);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule